// File: doc/BRIEF.md
# Constant-Time Modular Exponentiator (Ladder Form)

This block raises a base to an exponent modulo an odd modulus, `result = base^exp mod mod`, with every operand `W` bits wide. The caller also supplies three constants tied to the modulus and to `R = 2^W`: `R mod N`, `R^2 mod N` and the negated modular inverse `-N^-1 mod R`. The block does not derive these constants itself. All modular products come from one internal Montgomery multiplier. The multiplier has a fixed pipeline depth and always performs its final conditional subtraction as a multiplexer choice.

The exponent is scanned by the ladder method with two working registers, starting from the most significant of all `W` bits, leading zeros included. Every bit costs one cross product and one squaring. The bit value only decides which register receives each product. As a result, the time from start to done is the same for every exponent, base and modulus. Operands enter the Montgomery domain by one product with `R^2 mod N`, the accumulator starts at `R mod N`, and a final product with 1 takes the value back out of the domain.

A request is accepted by a `start` pulse while the block is idle. `busy` covers the run. `done` pulses for one cycle together with the new result.

Top module: `modexp_ladder`

## Requirements
- R1: When `done` is high, `result` equals `base^exp mod mod` for any odd modulus above 1, any base below the modulus and any exponent. An exponent of 0 gives 1.
- R2: `done` rises exactly `5*(2W+2)` clock cycles after the rising edge that accepts `start`, whatever the values of base, exponent and modulus.
- R3: `done` is high for exactly one cycle per request. `result` changes only in a cycle where `done` is high, and it then holds until the next completion.
- R4: `busy` is high from the cycle after an accepted `start` up to the cycle before `done`. It is low in the cycle where `done` is high.
- R5: A `start` pulse while `busy` is high starts nothing. The running request completes at its own due cycle with its own result.
- R6: Operand and constant inputs are captured only on an accepted `start`. Changing them during a run does not alter that run's result.
- R7: After reset, `busy`, `done` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, accepted only when idle |
| base_in | input | W | Base, below the modulus |
| exp_in | input | W | Exponent |
| mod_in | input | W | Odd modulus above 1 |
| rmod_in | input | W | R mod modulus, with R = 2^W |
| r2mod_in | input | W | R^2 mod modulus |
| ninv_in | input | W | -modulus^-1 mod R |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | W | base^exp mod modulus |

## Verification
Each request runs 2W+2 Montgomery products of 5 cycles each, so its result is due exactly 5*(2W+2) cycles after the accepting edge. For the 8-bit configuration of the bench that is 90 cycles. The bench counts rising edges from the accepting edge and samples 1 ns after each one. It requires `done` on exactly the 90th edge, `busy` already high after the first edge, and `done` low again one edge later. A run that is disturbed by a second `start` and new operands at edge 30 must still finish at edge 90 with the value of the original operands.

// File: rtl/modexp_ladder_pkg.sv
// Shared types for the ladder exponentiator.
// Assumes nothing beyond a standard SystemVerilog compile.
package modexp_ladder_pkg;

    // Controller states: every product has an issue cycle and a wait phase.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENTER_GO,
        ST_ENTER_WAIT,
        ST_CROSS_GO,
        ST_CROSS_WAIT,
        ST_SQR_GO,
        ST_SQR_WAIT,
        ST_EXIT_GO,
        ST_EXIT_WAIT
    } ladder_state_t;

    // Latency of one Montgomery product, from issue cycle to write-back edge.
    localparam int unsigned OP_CYCLES = 5;

endpackage

// File: rtl/mont_mul.sv
// Montgomery product res = a*b*R^-1 mod n, with R = 2^W.
// Four register stages: full product, reduction factor, reduced sum,
// final subtraction. The subtraction is always computed and selected by
// a multiplexer, so the latency is fixed at 4 edges after go.
// Assumes n odd, a < n, b < n, np = -n^-1 mod R; n and np held stable.
module mont_mul #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    input  logic [W-1:0] np,
    output logic         vld,
    output logic [W-1:0] res
);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned TW = 2 * W + 1;

    logic [PW-1:0] t1_q, t2_q;
    logic [W-1:0]  m_q;
    logic [W:0]    s_q;
    logic [3:0]    v_q;
    logic [W-1:0]  m_d;
    logic [W:0]    s_d;
    logic [W:0]    n_ext;

    assign n_ext = {1'b0, n};
    assign m_d   = t1_q[W-1:0] * np;
    assign s_d   = (W+1)'((TW'(t2_q) + TW'(m_q) * TW'(n)) >> W);

    // Valid flag travels with the data through the four stages.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= {v_q[2:0], go};
    end

    // Data stages; no reset needed since the valid flag qualifies them.
    always_ff @(posedge clk) begin
        t1_q <= PW'(a) * PW'(b);
        t2_q <= t1_q;
        m_q  <= m_d;
        s_q  <= s_d;
        res  <= (s_q >= n_ext) ? W'(s_q - n_ext) : s_q[W-1:0];
    end

    assign vld = v_q[3];

endmodule

// File: rtl/exp_bits.sv
// Exponent scanner: presents exponent bits from the most significant down
// to the least significant and flags the last one. It always walks all W
// bits, so leading zeros cost the same as any other bit.
module exp_bits #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] exp_in,
    input  logic         advance,
    output logic         bit_cur,
    output logic         last_bit
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    // Shift register and remaining-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= exp_in;
            cnt_q <= CW'(W - 1);
        end else if (advance) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign bit_cur  = sh_q[W-1];
    assign last_bit = (cnt_q == '0);

endmodule

// File: rtl/modexp_ladder.sv
// Top of the constant-time exponentiator. Captures the operands on an
// accepted start and enters the Montgomery domain (r0 = R mod n,
// r1 = mont(y, R^2)). Each exponent bit then runs a cross product and a
// squaring into swapped registers, and a final mont(r0, 1) leaves the
// domain. Assumes odd n > 1, base < n and correct constants.
module modexp_ladder
    import modexp_ladder_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] base_in,
    input  logic [W-1:0] exp_in,
    input  logic [W-1:0] mod_in,
    input  logic [W-1:0] rmod_in,
    input  logic [W-1:0] r2mod_in,
    input  logic [W-1:0] ninv_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    ladder_state_t state_q;
    logic [W-1:0]  base_q, mod_q, r2_q, ninv_q, r0_q, r1_q;
    logic [W-1:0]  op_a, op_b, mul_res;
    logic          mul_go, mul_vld, bit_cur, last_bit, accept, step_adv;

    assign accept   = start && (state_q == ST_IDLE);
    assign step_adv = (state_q == ST_SQR_WAIT) && mul_vld;
    assign busy     = (state_q != ST_IDLE);

    // Operand selection: which registers feed the multiplier in each phase.
    always_comb begin
        op_a   = r0_q;
        op_b   = r1_q;
        mul_go = 1'b0;
        unique case (state_q)
            ST_ENTER_GO: begin op_a = base_q; op_b = r2_q; mul_go = 1'b1; end
            ST_CROSS_GO: begin mul_go = 1'b1; end
            ST_SQR_GO: begin
                op_a   = bit_cur ? r1_q : r0_q;
                op_b   = bit_cur ? r1_q : r0_q;
                mul_go = 1'b1;
            end
            ST_EXIT_GO: begin op_b = W'(1); mul_go = 1'b1; end
            default: ;
        endcase
    end

    // Sequencer with register write-back and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            result  <= '0;
            base_q  <= '0;
            mod_q   <= '0;
            r2_q    <= '0;
            ninv_q  <= '0;
            r0_q    <= '0;
            r1_q    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    base_q  <= base_in;
                    mod_q   <= mod_in;
                    r2_q    <= r2mod_in;
                    ninv_q  <= ninv_in;
                    r0_q    <= rmod_in;
                    state_q <= ST_ENTER_GO;
                end
                ST_ENTER_GO: state_q <= ST_ENTER_WAIT;
                ST_ENTER_WAIT: if (mul_vld) begin
                    r1_q    <= mul_res;
                    state_q <= ST_CROSS_GO;
                end
                ST_CROSS_GO: state_q <= ST_CROSS_WAIT;
                ST_CROSS_WAIT: if (mul_vld) begin
                    if (bit_cur) r0_q <= mul_res;
                    else         r1_q <= mul_res;
                    state_q <= ST_SQR_GO;
                end
                ST_SQR_GO: state_q <= ST_SQR_WAIT;
                ST_SQR_WAIT: if (mul_vld) begin
                    if (bit_cur) r1_q <= mul_res;
                    else         r0_q <= mul_res;
                    state_q <= last_bit ? ST_EXIT_GO : ST_CROSS_GO;
                end
                ST_EXIT_GO: state_q <= ST_EXIT_WAIT;
                ST_EXIT_WAIT: if (mul_vld) begin
                    result  <= mul_res;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    exp_bits #(.W(W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .exp_in   (exp_in),
        .advance  (step_adv),
        .bit_cur  (bit_cur),
        .last_bit (last_bit)
    );

    mont_mul #(.W(W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .a     (op_a),
        .b     (op_b),
        .n     (mod_q),
        .np    (ninv_q),
        .vld   (mul_vld),
        .res   (mul_res)
    );

endmodule

// File: rtl/modexp_ladder_chk.sv
// Property checker for modexp_ladder, attached by bind. It keeps its own
// cycle counter to check the fixed latency without a long $past window.
module modexp_ladder_chk
    import modexp_ladder_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic [W-1:0] mod_q
);
    localparam int unsigned LAT = OP_CYCLES * (2 * W + 2);
    localparam int unsigned KW  = $clog2(LAT + 2);

    logic [KW-1:0] cyc_q;

    // Cycles elapsed since the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)              cyc_q <= '0;
        else if (start && !busy) cyc_q <= '0;
        else if (busy)           cyc_q <= cyc_q + 1'b1;
    end

    // R1
    result_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < mod_q));

    // R2
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_q == KW'(LAT)));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R4
    busy_off_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind modexp_ladder modexp_ladder_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .mod_q  (mod_q)
);

// File: tb/modexp_ladder_test.sv
// Bench: near-exhaustive sweeps over an 8-bit configuration, expected
// values computed by plain integer arithmetic.
module modexp_ladder_test;
    localparam int W   = 8;
    localparam int LAT = 5 * (2 * W + 2);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] base_in = '0, exp_in = '0, mod_in = '0;
    logic [W-1:0] rmod_in = '0, r2mod_in = '0, ninv_in = '0;
    logic         busy, done;
    logic [W-1:0] result;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    modexp_ladder #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_in(base_in), .exp_in(exp_in), .mod_in(mod_in),
        .rmod_in(rmod_in), .r2mod_in(r2mod_in), .ninv_in(ninv_in),
        .busy(busy), .done(done), .result(result)
    );

    function automatic int powmod(int y, int c, int n);
        int r = 1 % n;
        for (int i = W - 1; i >= 0; i--) begin
            r = (r * r) % n;
            if ((c >> i) & 1) r = (r * y) % n;
        end
        return r;
    endfunction

    function automatic int neg_inv(int n);
        for (int x = 1; x < 256; x++)
            if (((n * x) & 255) == 1) return (256 - x) & 255;
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One request; with disturb set, a second start and new operands arrive mid-run.
    task automatic run(int y, int c, int n, bit disturb);
        int lat = 0;
        int exp_val = powmod(y, c, n);
        logic [W-1:0] got;
        @(negedge clk);
        base_in = W'(y); exp_in = W'(c); mod_in = W'(n);
        rmod_in = W'(256 % n); r2mod_in = W'(65536 % n); ninv_in = W'(neg_inv(n));
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (disturb) check("R4 busy after start", busy, 1);
        for (int k = 0; k < LAT + 20; k++) begin
            @(posedge clk); #1;
            lat++;
            if (disturb && lat == 30) begin
                start = 1'b1; base_in = 8'd3; exp_in = 8'd1;
                mod_in = 8'd9; rmod_in = 8'd4; r2mod_in = 8'd7; ninv_in = 8'd199;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        got = result;
        check(disturb ? "R1/R5/R6 result" : "R1 result", int'(got), exp_val);
        check("R2 latency", lat, LAT);
        if (disturb) check("R4 busy low at done", busy, 0);
        @(posedge clk); #1;
        check("R3 done one cycle", done, 0);
        if (disturb) begin
            repeat (3) @(posedge clk);
            #1 check("R3 result holds", int'(result), int'(got));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R7 reset state
        check("R7 busy", busy, 0);
        check("R7 done", done, 0);
        check("R7 result", int'(result), 0);
        @(negedge clk) rst_n = 1'b1;

        // R1/R2 every exponent, including 0 and 255, one modulus
        for (int c = 0; c < 256; c++) run(7, c, 251, 1'b0);
        // R1 every odd modulus, bases at edge and middle
        for (int n = 3; n < 256; n += 2) begin
            run(n - 1, 8'hB5, n, 1'b0);
            run(n / 2, 8'h2D, n, 1'b0);
        end
        // R1 every base with small exponents, including base 0
        for (int y = 0; y < 13; y++)
            for (int c = 0; c < 16; c++) run(y, c, 13, 1'b0);
        // R5/R6/R4/R3 disturbed runs
        run(5, 200, 221, 1'b1);
        run(254, 255, 255, 1'b1);
        run(2, 45, 251, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule